// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Register Bank

This block is the digital front end of a two-channel digital-to-analog converter that is fed from a parallel bus. Each channel has two register ranks: a staging register that the bus writes into, and a DAC register that holds the code the converter presents. A write goes to the staging register of one channel, picked by a channel-select bit. A separate load strobe for each channel copies staging into DAC. Software can stage both channels one at a time and then pulse both load strobes together so that the two outputs change in the same cycle.

All strobes are active low. The chip-select, load and reset inputs pass through two-flop synchronizers into the system clock domain. A small state machine watches the synchronized chip-select. In `WS_IDLE` it waits for chip-select to go low and then moves to `WS_HELD`. In `WS_HELD` it waits for chip-select to return high. That transition back to `WS_IDLE` is the commit: it writes the bus data into the staging register of the addressed channel. The reset input clears every register at once, without waiting for a clock. Its release is synchronized. The shutdown input drops both output-enable flags, which models open output buffers, while writes and loads keep working. A parameter selects a 10-bit variant. That variant takes its code from the low bus bits, so its full-scale code is 3FF hex instead of FFF hex.

Top module: `dual_dac_regbank`

## Requirements
- R1: With the default parameter, `din` and both channel codes are 12 bits wide, and a staged value travels unchanged through both ranks.
- R2: A write commits to a staging register on the clock edge where the state machine leaves `WS_HELD`. This is the third rising clock edge after `wr_n` rises, provided `wr_n` was low for at least two sampled edges. The value committed is `din` sampled at that edge. `ch_sel` = 0 selects channel A and `ch_sel` = 1 selects channel B. While `wr_n` is high and no commit is pending, `din` and `ch_sel` have no effect.
- R3: The DAC register of channel A loads from staging register A on every clock edge at which the synchronized `ld_a_n` is low. That is the third rising edge after `ld_a_n` falls. `ld_b_n` does the same for channel B. A staged value does not appear on `code_a` or `code_b` until it is loaded.
- R4: When `ld_a_n` and `ld_b_n` are low in the same cycles, both DAC registers update on the same clock edge.
- R5: While `rst_n` is low, both staging registers and both DAC registers are zero at once, without waiting for a clock. Writes and loads attempted while `rst_n` is low are lost. Reset can be applied again at any time during operation.
- R6: While `pdn_n` is low, `drive_a` and `drive_b` are 0. Writes and loads still take effect.
- R7: When `pdn_n` returns high, both drive flags are 1 in the same cycle, and the codes show the current DAC registers, including any values loaded during shutdown.
- R8: If a commit to a channel and that channel's synchronized load fall on the same clock edge, the DAC register takes the newly committed `din` value and not the old staging content.
- R9: With `CODE_W` = 10, the code is taken from `din[9:0]` and `din[11:10]` are ignored. The full-scale code is 3FF hex.
- R10: After `rst_n` rises, the first clock edge at which a strobe can take effect is the third one, because the reset release is synchronized over two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every strobe is sampled in this domain |
| rst_n | input | 1 | Active-low reset; clears at once, released synchronously |
| wr_n | input | 1 | Active-low chip-select write strobe; the rising edge commits |
| ch_sel | input | 1 | Channel address for a write: 0 selects A, 1 selects B |
| din | input | 12 | Parallel code bus |
| ld_a_n | input | 1 | Active-low load strobe for channel A |
| ld_b_n | input | 1 | Active-low load strobe for channel B |
| pdn_n | input | 1 | Active-low shutdown input |
| code_a | output | CODE_W (12) | DAC register of channel A |
| code_b | output | CODE_W (12) | DAC register of channel B |
| drive_a | output | 1 | Channel A output enable; 0 means the output is open |
| drive_b | output | 1 | Channel B output enable; 0 means the output is open |

## Verification
The hardest case to reach is the forwarding case of R8. The commit and the load of the same channel must land on the same clock edge, and the two signals pass through synchronizer chains whose timing relative to each other differs. The stimulus raises `wr_n` and lowers `ld_a_n` at the same falling edge, so both arrive three edges later together. It holds `din` at a value that differs from the old staging content, so a missed forward shows up as a wrong code. A second hard case is a load issued during shutdown, followed by release. The bench runs a 12-bit and a 10-bit instance side by side from the same stimulus, and it drives upper bus bits that the narrow instance must drop.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
    localparam int BUS_W = 12;
    localparam int NCH   = 2;

    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_HELD = 1'b1
    } wr_state_e;
endpackage

// File: rtl/dacbank_sync.sv
module dacbank_sync #(
    parameter int             W    = 1,
    parameter logic [W-1:0]   INIT = '0
) (
    input  logic         clk,
    input  logic         rst_ni,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= INIT;
            stab_q <= INIT;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/dacbank_wr_fsm.sv
module dacbank_wr_fsm
    import dacbank_pkg::*;
(
    input  logic clk,
    input  logic rst_ni,
    input  logic cs_sync_n,
    output logic commit
);
    wr_state_e state_q;
    wr_state_e state_d;

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) state_q <= WS_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            WS_IDLE: begin
                if (!cs_sync_n) state_d = WS_HELD;
            end
            WS_HELD: begin
                if (cs_sync_n) begin
                    state_d = WS_IDLE;
                    commit  = 1'b1;
                end
            end
            default: state_d = WS_IDLE;
        endcase
    end

    // R2: a commit lasts exactly one cycle
    p_commit_single_r2: assert property (@(posedge clk) disable iff (!rst_ni)
        commit |=> !commit);

    // R2: a commit only follows a cycle in which chip-select was held low
    p_commit_after_low_r2: assert property (@(posedge clk) disable iff (!rst_ni)
        commit |-> $past(!cs_sync_n));
endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_ni,
    input  logic              wr,
    input  logic              ld,
    input  logic [CODE_W-1:0] d,
    output logic [CODE_W-1:0] dac
);
    logic [CODE_W-1:0] stage_q;
    logic [CODE_W-1:0] dac_q;

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            stage_q <= '0;
        end else if (wr) begin
            stage_q <= d;
        end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            dac_q <= '0;
        end else if (ld) begin
            dac_q <= wr ? d : stage_q;
        end
    end

    assign dac = dac_q;

    // R2: a commit captures the bus value
    p_stage_capture_r2: assert property (@(posedge clk) disable iff (!rst_ni)
        wr |=> (stage_q == $past(d)));

    // R2: without a commit the staging register holds
    p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rst_ni)
        !wr |=> $stable(stage_q));

    // R3: a load without a commit copies the staging register
    p_load_copy_r3: assert property (@(posedge clk) disable iff (!rst_ni)
        (ld && !wr) |=> (dac_q == $past(stage_q)));

    // R3: without a load the DAC register holds
    p_dac_hold_r3: assert property (@(posedge clk) disable iff (!rst_ni)
        !ld |=> $stable(dac_q));

    // R8: a load and a commit together forward the bus value
    p_forward_r8: assert property (@(posedge clk) disable iff (!rst_ni)
        (ld && wr) |=> (dac_q == $past(d)));
endmodule

// File: rtl/dual_dac_regbank.sv
module dual_dac_regbank
    import dacbank_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              ch_sel,
    input  logic [BUS_W-1:0]  din,
    input  logic              ld_a_n,
    input  logic              ld_b_n,
    input  logic              pdn_n,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              drive_a,
    output logic              drive_b
);
    localparam int STRB_W = NCH + 1;

    logic              rst_i_n;
    logic [STRB_W-1:0] strb_raw;
    logic [STRB_W-1:0] strb_s;
    logic              commit;
    logic [NCH-1:0]    ld_s;
    logic [NCH-1:0]    wr_vec;
    logic [CODE_W-1:0] dac_q [NCH];

    dacbank_sync #(.W(1), .INIT(1'b0)) u_rst_sync (
        .clk    (clk),
        .rst_ni (rst_n),
        .d      (1'b1),
        .q      (rst_i_n)
    );

    assign strb_raw = {ld_b_n, ld_a_n, wr_n};

    dacbank_sync #(.W(STRB_W), .INIT({STRB_W{1'b1}})) u_strb_sync (
        .clk    (clk),
        .rst_ni (rst_i_n),
        .d      (strb_raw),
        .q      (strb_s)
    );

    dacbank_wr_fsm u_wr_fsm (
        .clk       (clk),
        .rst_ni    (rst_i_n),
        .cs_sync_n (strb_s[0]),
        .commit    (commit)
    );

    assign ld_s = ~strb_s[STRB_W-1:1];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        assign wr_vec[ch] = commit && (ch_sel == 1'(ch));

        dacbank_chan #(.CODE_W(CODE_W)) u_chan (
            .clk    (clk),
            .rst_ni (rst_i_n),
            .wr     (wr_vec[ch]),
            .ld     (ld_s[ch]),
            .d      (din[CODE_W-1:0]),
            .dac    (dac_q[ch])
        );
    end

    assign code_a  = dac_q[0];
    assign code_b  = dac_q[1];
    assign drive_a = pdn_n;
    assign drive_b = pdn_n;

    // R5: reset held means both codes are zero-scale
    p_reset_zero_r5: assert property (@(posedge clk)
        !rst_n |-> (code_a == '0 && code_b == '0));

    // R10: internal release comes two sampled edges after the pin rises
    p_release_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_i_n) |-> ($past(rst_n) && $past(rst_n, 2)));

    // R2: at most one channel receives a commit
    p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
        $onehot0(wr_vec));
endmodule

// File: tb/test_dual_dac_regbank.sv
module test_dual_dac_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_n = 1'b1;
    logic        ch_sel = 1'b0;
    logic [11:0] din = 12'h000;
    logic        ld_a_n = 1'b1;
    logic        ld_b_n = 1'b1;
    logic        pdn_n = 1'b1;

    logic [11:0] code_a, code_b;
    logic        drive_a, drive_b;
    logic [9:0]  nar_a, nar_b;
    logic        nar_drv_a, nar_drv_b;

    always #4 clk = ~clk;

    dual_dac_regbank #(.CODE_W(12)) i_dual_dac_regbank (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .ch_sel(ch_sel), .din(din),
        .ld_a_n(ld_a_n), .ld_b_n(ld_b_n), .pdn_n(pdn_n),
        .code_a(code_a), .code_b(code_b), .drive_a(drive_a), .drive_b(drive_b)
    );

    dual_dac_regbank #(.CODE_W(10)) i_dual_dac_regbank_n10 (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .ch_sel(ch_sel), .din(din),
        .ld_a_n(ld_a_n), .ld_b_n(ld_b_n), .pdn_n(pdn_n),
        .code_a(nar_a), .code_b(nar_b), .drive_a(nar_drv_a), .drive_b(nar_drv_b)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R5";
    bit    started = 0;
    bit    done = 0;

    // behavioural reference model
    int stage_m [2];
    int dac_m   [2];
    bit cs_h[$], la_h[$], lb_h[$];
    bit held_m;
    int rel_cnt;

    task automatic model_clear();
        stage_m[0] = 0; stage_m[1] = 0;
        dac_m[0] = 0;   dac_m[1] = 0;
        cs_h = '{1'b1, 1'b1};
        la_h = '{1'b1, 1'b1};
        lb_h = '{1'b1, 1'b1};
        held_m = 0;
    endtask

    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            model_clear();
            rel_cnt = 0;
        end else if (rel_cnt < 2) begin
            model_clear();
            rel_cnt++;
        end else begin
            bit cs_now, la_now, lb_now, commit_now;
            int wch, wd, old_a, old_b;
            cs_now = cs_h[0]; la_now = !la_h[0]; lb_now = !lb_h[0];
            commit_now = held_m && cs_now;
            wch = ch_sel; wd = din;
            old_a = stage_m[0]; old_b = stage_m[1];
            if (la_now) dac_m[0] = (commit_now && wch == 0) ? wd : old_a;
            if (lb_now) dac_m[1] = (commit_now && wch == 1) ? wd : old_b;
            if (commit_now) stage_m[wch] = wd;
            held_m = !cs_now;
            void'(cs_h.pop_front()); cs_h.push_back(wr_n);
            void'(la_h.pop_front()); la_h.push_back(ld_a_n);
            void'(lb_h.pop_front()); lb_h.push_back(ld_b_n);
        end
    end

    task automatic cmp(string name, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, name, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            cmp("code_a",   code_a,  dac_m[0]);
            cmp("code_b",   code_b,  dac_m[1]);
            cmp("drive_a",  drive_a, pdn_n);
            cmp("drive_b",  drive_b, pdn_n);
            // R9: narrow variant keeps only the low ten bits
            cmp("n10 code_a", nar_a, dac_m[0] & 12'h3FF);
            cmp("n10 code_b", nar_b, dac_m[1] & 12'h3FF);
            cmp("n10 drive_a", nar_drv_a, pdn_n);
            cmp("n10 drive_b", nar_drv_b, pdn_n);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_write(bit ch, logic [11:0] v);
        step(1);
        wr_n = 0; ch_sel = ch; din = v;
        step(3);
        wr_n = 1;
        step(4);
        din = ~v; ch_sel = ~ch;
        step(2);
    endtask

    task automatic do_load(bit a, bit b);
        step(1);
        ld_a_n = !a; ld_b_n = !b;
        step(1);
        ld_a_n = 1; ld_b_n = 1;
        step(4);
    endtask

    initial begin
        // R5: reset state, with strobes toggled while reset is held
        cur_req = "R5";
        step(2);
        wr_n = 0; din = 12'h5A5; ld_a_n = 0; ld_b_n = 0;
        step(3);
        wr_n = 1;
        step(3);
        ld_a_n = 1; ld_b_n = 1;
        // R10: release, and a write pulse that straddles the release edges
        cur_req = "R10";
        rst_n = 1; wr_n = 0; din = 12'h123; ch_sel = 0;
        step(1);
        wr_n = 1;
        step(6);
        do_load(1, 1);
        // R2: stage both channels, nothing visible yet
        cur_req = "R2";
        do_write(0, 12'hABC);
        do_write(1, 12'hF0F);
        step(3);
        // R3: independent loads
        cur_req = "R3";
        do_load(1, 0);
        do_load(0, 1);
        // R1: full-scale and pattern values through both ranks
        cur_req = "R1";
        do_write(0, 12'hFFF);
        do_load(1, 0);
        // R4: simultaneous load
        cur_req = "R4";
        do_write(0, 12'h3C7);
        do_write(1, 12'hC38);
        do_load(1, 1);
        // R8: commit and load of channel A on the same edge
        cur_req = "R8";
        step(1);
        wr_n = 0; ch_sel = 0; din = 12'h9E1;
        step(3);
        wr_n = 1; ld_a_n = 0;
        step(1);
        ld_a_n = 1;
        step(4);
        // R8 on channel B
        wr_n = 0; ch_sel = 1; din = 12'h46D;
        step(3);
        wr_n = 1; ld_b_n = 0;
        step(1);
        ld_b_n = 1;
        step(5);
        // R6: shutdown, loads still work
        cur_req = "R6";
        pdn_n = 0;
        step(2);
        do_write(0, 12'h7F0);
        do_write(1, 12'h00F);
        do_load(1, 1);
        // R7: release shows the values loaded during shutdown
        cur_req = "R7";
        pdn_n = 1;
        step(3);
        // R9: upper bits differ from lower bits
        cur_req = "R9";
        do_write(1, 12'hC00);
        do_load(0, 1);
        do_write(0, 12'h3FF);
        do_load(1, 0);
        // R5: on-demand reset during operation
        cur_req = "R5";
        rst_n = 0;
        step(3);
        rst_n = 1;
        step(4);
        do_load(1, 1);
        step(3);
        finish_run();
    end
endmodule